// File: doc/BRIEF.md
# Warp Divergence Mask Stack

This block tracks which lanes of a single warp are enabled while the warp runs through conditional branches, and which instruction address the warp should fetch next. Each lane is one thread; lane k holds the k-th thread of the warp, counted upward from the warp's lowest thread id. The scheduler steps the block once for each instruction it issues. For a branch it supplies a predicate bit per lane, a target address and the address where both sides of the branch meet again.

When the enabled lanes all agree on a branch, the warp simply follows that one side. When they disagree, the block pushes an entry onto a small stack. The entry records the meeting address, the address and lane set of the side still to run, and the mask the warp had before the branch. The taken side runs first with only its lanes enabled. When the fetch address reaches the meeting address, the block switches to the other side. When that side also arrives there, the block pops the entry and restores the full mask. Each switch and each pop takes one cycle, and during that cycle the block refuses new steps. Branches nested inside one another use deeper stack levels. A divergent branch that would need more levels than exist latches an overflow flag and freezes the warp until the next launch.

Top module: `simt_mask_stack`

## Requirements
- R1: Reset (asynchronous, active low) sets the fetch address to RESET_PC (default 0), the mask to all ones, ready high, overflow low, and empties the stack.
- R2: A launch with a nonzero mask loads the fetch address and mask, empties the stack and clears overflow in one cycle. A launch with an all-zero mask has no effect.
- R3: An accepted non-branch step advances the fetch address by one and leaves the mask unchanged.
- R4: An accepted branch on which every enabled lane has predicate 1 jumps to the target, leaves the mask unchanged and pushes nothing.
- R5: An accepted branch on which every enabled lane has predicate 0 advances the fetch address by one and pushes nothing. Predicate bits of disabled lanes are ignored.
- R6: An accepted branch with both enabled predicate values present pushes an entry and jumps to the target. The new mask is the old mask AND the predicate (bit k = lane k).
- R7: When the stack is non-empty and the fetch address equals the top entry's meeting address while its other side is still pending, ready drops for one cycle. The block then moves to the branch address plus one, with the old mask AND NOT the predicate. A side with no lanes never runs.
- R8: When the fetch address equals the top meeting address and the other side has already run, ready drops for one cycle. The block then pops the entry and restores the mask from before the branch.
- R9: Nested entries resolve innermost first. Entries that share a meeting address resolve in consecutive cycles, one action per cycle.
- R10: A divergent branch stepped while all DEPTH levels are in use sets overflow and drops ready. Address and mask then hold until a launch.
- R11: A step presented while ready is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| launch_i | input | 1 | Load a new warp start state |
| launch_pc_i | input | PC_W | Start fetch address |
| launch_mask_i | input | LANES | Start lane mask |
| step_i | input | 1 | Current instruction issued |
| branch_i | input | 1 | Issued instruction is a conditional branch |
| pred_i | input | LANES | Per-lane branch predicate, 1 = taken |
| target_pc_i | input | PC_W | Branch target address |
| reconv_pc_i | input | PC_W | Meeting address of the branch |
| pc_o | output | PC_W | Address to fetch |
| mask_o | output | LANES | Enabled lanes |
| ready_o | output | 1 | Step accepted this cycle |
| overflow_o | output | 1 | Sticky stack overflow |

## Verification
The bench builds the block with LANES = 32, PC_W = 16 and DEPTH = 2. The two-level stack lets a second nested divergence fill the stack and a third one overflow within a few steps. The same setting also covers the case where both levels share one meeting address and the two pops follow each other. The full 32-lane mask lets the tests split on half-words, bytes and nibble patterns, and lets them set predicate bits only on disabled lanes.

// File: rtl/sms_pkg.sv
package sms_pkg;

  typedef enum logic [1:0] {
    CLS_SEQ,    // not a branch
    CLS_TAKEN,  // all enabled lanes take it
    CLS_FALL,   // no enabled lane takes it
    CLS_SPLIT   // lanes disagree
  } br_cls_e;

endpackage

// File: rtl/sms_lane_split.sv
module sms_lane_split
  import sms_pkg::*;
#(
  parameter int LANES = 32
) (
  input  logic             is_br_i,
  input  logic [LANES-1:0] mask_i,
  input  logic [LANES-1:0] pred_i,
  output logic [LANES-1:0] taken_o,
  output logic [LANES-1:0] fall_o,
  output br_cls_e          cls_o
);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign taken_o[k] = mask_i[k] & pred_i[k];
    assign fall_o[k]  = mask_i[k] & ~pred_i[k];
  end

  always_comb begin
    if (!is_br_i)          cls_o = CLS_SEQ;
    else if (fall_o == '0) cls_o = CLS_TAKEN;
    else if (taken_o == '0) cls_o = CLS_FALL;
    else                   cls_o = CLS_SPLIT;
  end

endmodule

// File: rtl/sms_stack.sv
module sms_stack #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  input  logic         pop_i,
  input  logic         upd_i,
  input  logic [W-1:0] upd_data_i,
  output logic [W-1:0] top_o,
  output logic         empty_o,
  output logic         full_o
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic [W-1:0]     slot_q [DEPTH];
  logic [IDX_W-1:0] top_idx, wr_idx;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign top_idx = IDX_W'(cnt_q - 1'b1);
  assign wr_idx  = IDX_W'(cnt_q);
  assign top_o   = empty_o ? '0 : slot_q[top_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clr_i)                cnt_q <= '0;
    else if (push_i && !full_o)    cnt_q <= cnt_q + 1'b1;
    else if (pop_i && !empty_o)    cnt_q <= cnt_q - 1'b1;
  end

  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        slot_q[k] <= '0;
      else if (push_i && !full_o && wr_idx == IDX_W'(k))
        slot_q[k] <= push_data_i;
      else if (upd_i && !empty_o && top_idx == IDX_W'(k))
        slot_q[k] <= upd_data_i;
    end
  end

  // R10: never push into a full stack
  a_r10_push_room: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  // R8: never pop an empty stack
  a_r8_pop_nonempty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  // R9: one stack action per cycle
  a_r9_single_action: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({push_i, pop_i, upd_i}) <= 1);

endmodule

// File: rtl/simt_mask_stack.sv
module simt_mask_stack
  import sms_pkg::*;
#(
  parameter int          LANES    = 32,
  parameter int          PC_W     = 16,
  parameter int          DEPTH    = 4,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  logic [PC_W-1:0]  launch_pc_i,
  input  logic [LANES-1:0] launch_mask_i,
  input  logic             step_i,
  input  logic             branch_i,
  input  logic [LANES-1:0] pred_i,
  input  logic [PC_W-1:0]  target_pc_i,
  input  logic [PC_W-1:0]  reconv_pc_i,
  output logic [PC_W-1:0]  pc_o,
  output logic [LANES-1:0] mask_o,
  output logic             ready_o,
  output logic             overflow_o
);

  // entry layout, LSB first: full_mask, alt_mask, alt_pc, rpc, pend
  localparam int OFS_ALT_MASK = LANES;
  localparam int OFS_ALT_PC   = 2 * LANES;
  localparam int OFS_RPC      = 2 * LANES + PC_W;
  localparam int ENTRY_W      = 2 * LANES + 2 * PC_W + 1;

  logic [PC_W-1:0]    pc_q, pc_d;
  logic [LANES-1:0]   mask_q, mask_d;
  logic               ovf_q, ovf_d;

  logic [LANES-1:0]   taken, fall;
  br_cls_e            cls;

  logic               clr, push, pop, upd;
  logic [ENTRY_W-1:0] push_data, upd_data, top_w;
  logic               st_empty, st_full;

  logic               top_pend;
  logic [PC_W-1:0]    top_rpc, top_alt_pc;
  logic [LANES-1:0]   top_alt_mask, top_full_mask;
  logic               at_reconv, do_launch, accept;

  sms_lane_split #(.LANES(LANES)) i_split (
    .is_br_i (branch_i),
    .mask_i  (mask_q),
    .pred_i  (pred_i),
    .taken_o (taken),
    .fall_o  (fall),
    .cls_o   (cls)
  );

  sms_stack #(.W(ENTRY_W), .DEPTH(DEPTH)) i_stack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr),
    .push_i      (push),
    .push_data_i (push_data),
    .pop_i       (pop),
    .upd_i       (upd),
    .upd_data_i  (upd_data),
    .top_o       (top_w),
    .empty_o     (st_empty),
    .full_o      (st_full)
  );

  assign top_full_mask = top_w[LANES-1:0];
  assign top_alt_mask  = top_w[OFS_ALT_MASK +: LANES];
  assign top_alt_pc    = top_w[OFS_ALT_PC +: PC_W];
  assign top_rpc       = top_w[OFS_RPC +: PC_W];
  assign top_pend      = top_w[ENTRY_W-1];

  assign at_reconv = !st_empty && (pc_q == top_rpc);
  assign ready_o   = !at_reconv && !ovf_q;
  assign do_launch = launch_i && (launch_mask_i != '0);
  assign accept    = step_i && ready_o && !do_launch;

  assign push_data = {1'b1, reconv_pc_i, pc_q + 1'b1, fall, mask_q};
  assign upd_data  = {1'b0, top_w[ENTRY_W-2:0]};

  always_comb begin
    pc_d   = pc_q;
    mask_d = mask_q;
    ovf_d  = ovf_q;
    clr    = 1'b0;
    push   = 1'b0;
    pop    = 1'b0;
    upd    = 1'b0;
    if (do_launch) begin
      pc_d   = launch_pc_i;
      mask_d = launch_mask_i;
      ovf_d  = 1'b0;
      clr    = 1'b1;
    end else if (at_reconv && !ovf_q) begin
      if (top_pend) begin
        pc_d   = top_alt_pc;
        mask_d = top_alt_mask;
        upd    = 1'b1;
      end else begin
        mask_d = top_full_mask;
        pop    = 1'b1;
      end
    end else if (accept) begin
      unique case (cls)
        CLS_SEQ, CLS_FALL: pc_d = pc_q + 1'b1;
        CLS_TAKEN:         pc_d = target_pc_i;
        CLS_SPLIT: begin
          if (st_full) begin
            ovf_d = 1'b1;
          end else begin
            push   = 1'b1;
            pc_d   = target_pc_i;
            mask_d = taken;
          end
        end
        default: pc_d = pc_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= RESET_PC;
      mask_q <= '1;
      ovf_q  <= 1'b0;
    end else begin
      pc_q   <= pc_d;
      mask_q <= mask_d;
      ovf_q  <= ovf_d;
    end
  end

  assign pc_o       = pc_q;
  assign mask_o     = mask_q;
  assign overflow_o = ovf_q;

  // R6: an accepted step never enables a lane
  a_r6_mask_shrinks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> ((mask_o & ~$past(mask_o)) == '0));
  // R7: the warp never runs with no lanes
  a_r7_mask_nonempty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_o != '0);
  // R3: sequential step advances by one
  a_r3_seq_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !branch_i) |=> (pc_o == PC_W'($past(pc_o) + 1'b1)));
  // R10: overflow freezes the warp until launch
  a_r10_ovf_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overflow_o && !launch_i) |=> (overflow_o && $stable(pc_o) && $stable(mask_o)));
  // R11: refused step leaves no push
  a_r11_refused_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !ready_o) |-> !push);

endmodule

// File: tb/test_simt_mask_stack.sv
module test_simt_mask_stack;

  localparam int LANES = 32;
  localparam int PC_W  = 16;
  localparam int DEPTH = 2;
  localparam int NV    = 34;

  typedef struct packed {
    logic        ld;
    logic        st;
    logic        br;
    logic [31:0] pred;   // launch mask on ld rows
    logic [15:0] tgt;    // launch pc on ld rows
    logic [15:0] rpc;
    logic [15:0] epc;
    logic [31:0] emask;
    logic        erdy;
    logic        eerr;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t TBL [NV] = '{
    '{1,0,0,32'hFFFFFFFF,16'h0010,16'h0000,16'h0010,32'hFFFFFFFF,1,0,2},  // R2 launch
    '{0,1,0,32'h00000000,16'h0000,16'h0000,16'h0011,32'hFFFFFFFF,1,0,3},  // R3
    '{0,1,1,32'hFFFFFFFF,16'h0020,16'h0030,16'h0020,32'hFFFFFFFF,1,0,4},  // R4 uniform taken
    '{0,1,1,32'h00000000,16'h0040,16'h0021,16'h0021,32'hFFFFFFFF,1,0,5},  // R5 uniform fall, no push
    '{0,1,1,32'h0000FFFF,16'h0040,16'h0050,16'h0040,32'h0000FFFF,1,0,6},  // R6 split
    '{0,1,0,32'h00000000,16'h0000,16'h0000,16'h0041,32'h0000FFFF,1,0,3},  // R3
    '{0,1,1,32'h000000FF,16'h0048,16'h004A,16'h0048,32'h000000FF,1,0,6},  // R6 nested split
    '{0,1,0,32'h00000000,16'h0000,16'h0000,16'h0049,32'h000000FF,1,0,3},  // R3
    '{0,1,0,32'h00000000,16'h0000,16'h0000,16'h004A,32'h000000FF,0,0,7},  // R7 reach meeting
    '{0,1,0,32'h00000000,16'h0000,16'h0000,16'h0042,32'h0000FF00,1,0,11}, // R11 step ignored, R7 switch
    '{0,1,0,32'h00000000,16'h0000,16'h0000,16'h0043,32'h0000FF00,1,0,3},  // R3
    '{0,1,1,32'h0000FF00,16'h004A,16'h004A,16'h004A,32'h0000FF00,0,0,4},  // R4
    '{0,0,0,32'h00000000,16'h0000,16'h0000,16'h004A,32'h0000FFFF,1,0,8},  // R8 pop inner
    '{0,1,1,32'hFFFFFFFF,16'h0050,16'h0050,16'h0050,32'h0000FFFF,0,0,4},  // R4
    '{0,0,0,32'h00000000,16'h0000,16'h0000,16'h0022,32'hFFFF0000,1,0,7},  // R7 outer switch
    '{0,1,1,32'h0000FFFF,16'h0060,16'h0099,16'h0023,32'hFFFF0000,1,0,5},  // R5 disabled-lane preds ignored
    '{0,1,1,32'hFFFF0000,16'h0050,16'h0050,16'h0050,32'hFFFF0000,0,0,4},  // R4
    '{0,0,0,32'h00000000,16'h0000,16'h0000,16'h0050,32'hFFFFFFFF,1,0,8},  // R8 full restore
    '{0,1,1,32'h0F0F0F0F,16'h0060,16'h0070,16'h0060,32'h0F0F0F0F,1,0,6},  // R6
    '{0,1,1,32'h00000F0F,16'h0070,16'h0070,16'h0070,32'h00000F0F,0,0,9},  // R9 shared meeting
    '{0,0,0,32'h00000000,16'h0000,16'h0000,16'h0061,32'h0F0F0000,1,0,9},  // R9 inner switch
    '{0,1,1,32'h0F0F0000,16'h0070,16'h0070,16'h0070,32'h0F0F0000,0,0,4},  // R4
    '{0,0,0,32'h00000000,16'h0000,16'h0000,16'h0070,32'h0F0F0F0F,0,0,9},  // R9 inner pop, outer next
    '{0,0,0,32'h00000000,16'h0000,16'h0000,16'h0051,32'hF0F0F0F0,1,0,9},  // R9 outer switch
    '{0,1,1,32'hFFFFFFFF,16'h0070,16'h0070,16'h0070,32'hF0F0F0F0,0,0,4},  // R4
    '{0,0,0,32'h00000000,16'h0000,16'h0000,16'h0070,32'hFFFFFFFF,1,0,8},  // R8
    '{0,1,1,32'h000000FF,16'h0080,16'h0090,16'h0080,32'h000000FF,1,0,6},  // R6
    '{0,1,1,32'h0000000F,16'h0084,16'h0088,16'h0084,32'h0000000F,1,0,6},  // R6 stack full
    '{0,1,1,32'h00000003,16'h0086,16'h0087,16'h0084,32'h0000000F,0,1,10}, // R10 overflow
    '{0,1,0,32'h00000000,16'h0000,16'h0000,16'h0084,32'h0000000F,0,1,10}, // R10 frozen
    '{1,0,0,32'h0000FFFF,16'h0100,16'h0000,16'h0100,32'h0000FFFF,1,0,2},  // R2 relaunch clears
    '{0,1,1,32'h0000FFFF,16'h0088,16'h0099,16'h0088,32'h0000FFFF,1,0,2},  // R2 stale rpc gone
    '{1,0,0,32'h00000000,16'h0200,16'h0000,16'h0088,32'h0000FFFF,1,0,2},  // R2 zero-mask launch ignored
    '{0,1,1,32'h0000FFFF,16'h0090,16'h0090,16'h0090,32'h0000FFFF,1,0,4}   // R4 no push, no stall
  };

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             launch_i = 1'b0;
  logic [PC_W-1:0]  launch_pc_i = '0;
  logic [LANES-1:0] launch_mask_i = '0;
  logic             step_i = 1'b0;
  logic             branch_i = 1'b0;
  logic [LANES-1:0] pred_i = '0;
  logic [PC_W-1:0]  target_pc_i = '0;
  logic [PC_W-1:0]  reconv_pc_i = '0;
  logic [PC_W-1:0]  pc_o;
  logic [LANES-1:0] mask_o;
  logic             ready_o;
  logic             overflow_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  simt_mask_stack #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)) i_simt_mask_stack (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .launch_i      (launch_i),
    .launch_pc_i   (launch_pc_i),
    .launch_mask_i (launch_mask_i),
    .step_i        (step_i),
    .branch_i      (branch_i),
    .pred_i        (pred_i),
    .target_pc_i   (target_pc_i),
    .reconv_pc_i   (reconv_pc_i),
    .pc_o          (pc_o),
    .mask_o        (mask_o),
    .ready_o       (ready_o),
    .overflow_o    (overflow_o)
  );

  task automatic chk(input int req, input logic [15:0] epc, input logic [31:0] emask,
                     input logic erdy, input logic eerr);
    n_run++;
    if (pc_o !== epc || mask_o !== emask || ready_o !== erdy || overflow_o !== eerr) begin
      n_fail++;
      $display("FAIL R%0d: pc=%h mask=%h rdy=%b ovf=%b, expected pc=%h mask=%h rdy=%b ovf=%b",
               req, pc_o, mask_o, ready_o, overflow_o, epc, emask, erdy, eerr);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(1, 16'h0000, 32'hFFFFFFFF, 1'b1, 1'b0);  // R1 while in reset
    rst_ni = 1'b1;
    @(negedge clk);
    chk(1, 16'h0000, 32'hFFFFFFFF, 1'b1, 1'b0);  // R1 after release
    for (int i = 0; i < NV; i++) begin
      launch_i      = TBL[i].ld;
      launch_pc_i   = TBL[i].tgt;
      launch_mask_i = TBL[i].pred;
      step_i        = TBL[i].st;
      branch_i      = TBL[i].br;
      pred_i        = TBL[i].pred;
      target_pc_i   = TBL[i].tgt;
      reconv_pc_i   = TBL[i].rpc;
      @(negedge clk);
      chk(int'(TBL[i].req), TBL[i].epc, TBL[i].emask, TBL[i].erdy, TBL[i].eerr);
    end
    launch_i = 1'b0;
    step_i   = 1'b0;
    branch_i = 1'b0;
    // R1: asynchronous reset mid-cycle
    #2 rst_ni = 1'b0;
    #1 chk(1, 16'h0000, 32'hFFFFFFFF, 1'b1, 1'b0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule